// File: doc/BRIEF.md
# Interval-based cluster weight rebalancer

Four core clusters share a pool of arbitration slots that circulate from one cluster to the next. When a cluster leaves a slot unused, the slot is handed on to its successor, and that hand-off shows up here as a one-cycle conversion pulse for the cluster that passed the slot on. A separate strobe marks each arbitration slot released into the pool. The block counts both kinds of event over fixed observation windows. From these counts it derives a new priority weight per cluster for the next window.

A cluster's conversion count includes slots that it only forwarded from its predecessors. Its own surplus is therefore the difference between its count and its predecessor's count, and this difference can be negative when a cluster consumed slots that others freed. Each surplus, divided by the number of slots released in the window, is subtracted from the cluster's current weight. The result is clamped so that no cluster starves, then renormalised so the weights still sum to one. All of this completes within a fixed reconfiguration latency, and then the new weights are published together with a per-cluster slot quota for the next window.

The weights are unsigned fractions with 15 fraction bits (Q1.15), so one equals 32768. Weight i sits in `weightsOut[16i+15:16i]` and quota i sits in `slotQuota[9i+8:9i]`. The window length (300) must exceed the reconfiguration latency (20).

Top module: `slot_weight_rebalancer`

## Requirements
- R1: After reset every weight is 8192 (one quarter), `weightValid` is low, and the weights keep these values until the first publication.
- R2: Conversion pulses per cluster and release strobes are counted over consecutive windows of 300 cycles, the first of which starts in the first cycle after reset. An event in a window's last cycle counts in that window, and every window starts again from zero.
- R3: The surplus of cluster 0 is its conversion count, and the surplus of cluster i > 0 is its count minus the count of cluster i−1, as a signed value.
- R4: The weight correction of a cluster is |surplus|·32768/K truncated, where K is the number of release strobes in the window, carrying the sign of the surplus. When |surplus| ≥ K its magnitude is 32768.
- R5: The candidate weight is the current weight minus the correction, clamped to the range [512, 32768] (1/64 to one).
- R6: With S the sum of the clamped candidates, clusters 1 to 3 receive floor(candidate·32768/S) and cluster 0 receives 32768 minus their sum, so the published weights always sum to exactly 32768.
- R7: If K is zero in a window, the weights published for that window equal the current weights.
- R8: New weights appear, with a one-cycle `weightValid` pulse, exactly 20 cycles after a window's last cycle. At all other times the weights stay unchanged.
- R9: The quota of cluster i is floor(weight_i·300/32768), so a higher weight gives proportionally more slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| convPulse | input | 4 | Per-cluster pulse: an unused slot was handed to the next cluster |
| slotRelease | input | 1 | Pulse: one arbitration slot released |
| weightsOut | output | 64 | Four Q1.15 weights, cluster i in bits [16i+15:16i] |
| weightValid | output | 1 | One-cycle pulse when new weights are published |
| slotQuota | output | 36 | Four slot quotas for the next window, cluster i in bits [9i+8:9i] |

## Verification
Each window closes in the cycle where the cycle index since reset, modulo 300, is 299. Its weights, quotas and valid pulse are due in the cycle 20 later, and in every cycle before that the previous values must hold. The bench drives inputs and samples outputs on the falling edge. Its behavioural model accumulates each window's events in integers, computes the next weights at the window's last cycle, and schedules them for that cycle plus 20. Every output is compared in every cycle, so both an early and a late publication are caught.

// File: rtl/swr_pkg.sv
package swr_pkg;
  // Strobes issued by the sequencer to the arithmetic path
  typedef struct packed {
    logic snap;      // last cycle of a window: capture totals, restart counting
    logic loadEs;    // start surplus / K divisions
    logic loadNorm;  // start renormalising divisions
    logic commit;    // publish the renormalised weights
  } swrCtrl_t;
endpackage

// File: rtl/swr_frac_div.sv
// Sequential restoring fraction divider: quot = floor(num * 2^FRAC / den), needs num < den.
module swr_frac_div #(
  parameter int REM_W = 19,
  parameter int FRAC  = 15,
  parameter int BPC   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [REM_W-1:0] numIn,
  input  logic [REM_W-1:0] denIn,
  output logic [FRAC-1:0]  quot
);
  localparam int STEPS = (FRAC + BPC - 1) / BPC;
  localparam int QB    = STEPS * BPC;
  localparam int LW    = $clog2(STEPS + 1);

  logic [REM_W-1:0] remR, denR, remNx;
  logic [QB-1:0]    qR, qNx;
  logic [LW-1:0]    left;

  always_comb begin
    logic [REM_W:0] trial;
    remNx = remR;
    qNx   = qR;
    for (int b = 0; b < BPC; b++) begin
      trial = {remNx, 1'b0};
      if (trial >= {1'b0, denR}) begin
        remNx = REM_W'(trial - {1'b0, denR});
        qNx   = {qNx[QB-2:0], 1'b1};
      end else begin
        remNx = trial[REM_W-1:0];
        qNx   = {qNx[QB-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR <= '0;
      denR <= '0;
      qR   <= '0;
      left <= '0;
    end else if (load) begin
      remR <= numIn;
      denR <= denIn;
      qR   <= '0;
      left <= LW'(STEPS);
    end else if (left != '0) begin
      remR <= remNx;
      qR   <= qNx;
      left <= left - 1'b1;
    end
  end

  assign quot = FRAC'(qR >> (QB - FRAC));
endmodule

// File: rtl/swr_ctrl.sv
// Window timer and reconfiguration sequencer.
module swr_ctrl import swr_pkg::*; #(
  parameter int WINDOW     = 300,
  parameter int RECONF_LAT = 20,
  parameter int STEPS      = 8
) (
  input  logic     clk,
  input  logic     rstN,
  output swrCtrl_t ctrl
);
  localparam int WIN_W     = $clog2(WINDOW);
  localparam int LAT_W     = $clog2(RECONF_LAT);
  localparam int NORM_AT   = STEPS + 2;      // surplus quotients settle here
  localparam int COMMIT_AT = RECONF_LAT - 1; // publish edge; needs >= 2*STEPS+3

  logic [WIN_W-1:0] winPos;
  logic [LAT_W-1:0] lat;   // 0: idle, else cycles since window end
  logic             winEnd;

  assign winEnd = (winPos == WIN_W'(WINDOW - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) winPos <= '0;
    else       winPos <= winEnd ? '0 : winPos + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          lat <= '0;
    else if (winEnd)                    lat <= LAT_W'(1);
    else if (lat == LAT_W'(COMMIT_AT))  lat <= '0;
    else if (lat != '0)                 lat <= lat + 1'b1;
  end

  always_comb begin
    ctrl.snap     = winEnd;
    ctrl.loadEs   = (lat == LAT_W'(1));
    ctrl.loadNorm = (lat == LAT_W'(NORM_AT));
    ctrl.commit   = (lat == LAT_W'(COMMIT_AT));
  end
endmodule

// File: rtl/swr_datapath.sv
// Event counters, surplus arithmetic, shared dividers and weight registers.
module swr_datapath import swr_pkg::*; #(
  parameter int NUM_CLUSTERS  = 4,
  parameter int WINDOW        = 300,
  parameter int FRAC_BITS     = 15,
  parameter int MIN_SHIFT     = 6,
  parameter int BITS_PER_STEP = 2
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  swrCtrl_t                                   ctrl,
  input  logic [NUM_CLUSTERS-1:0]                    convPulse,
  input  logic                                       slotRelease,
  output logic [NUM_CLUSTERS*(FRAC_BITS+1)-1:0]      weightsOut,
  output logic                                       weightValid,
  output logic [NUM_CLUSTERS*$clog2(WINDOW+1)-1:0]   slotQuota
);
  localparam int WW      = FRAC_BITS + 1;
  localparam int CNT_W   = $clog2(WINDOW + 1);
  localparam int QUOTA_W = CNT_W;
  localparam int SUM_W   = WW + $clog2(NUM_CLUSTERS);
  localparam int REM_W   = ((CNT_W > SUM_W) ? CNT_W : SUM_W) + 1;
  localparam int SW      = WW + 2;
  localparam int PW      = WW + QUOTA_W;
  localparam logic [WW-1:0] ONE     = WW'(1) << FRAC_BITS;
  localparam logic [WW-1:0] MIN_W   = ONE >> MIN_SHIFT;
  localparam logic [WW-1:0] START_W = WW'(32'(ONE) / NUM_CLUSTERS);
  localparam logic signed [SW-1:0] MIN_S = SW'(MIN_W);
  localparam logic signed [SW-1:0] ONE_S = SW'(ONE);

  logic [CNT_W-1:0]     snapCnt [NUM_CLUSTERS];
  logic [WW-1:0]        wCur    [NUM_CLUSTERS];
  logic [WW-1:0]        wClamp  [NUM_CLUSTERS];
  logic [FRAC_BITS-1:0] quot    [NUM_CLUSTERS];
  logic [CNT_W-1:0]     relCnt, relSnap;
  logic [SUM_W-1:0]     wSum, qSum;

  // Slot releases counted per window (K)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relCnt  <= '0;
      relSnap <= '0;
    end else if (ctrl.snap) begin
      relSnap <= relCnt + CNT_W'(slotRelease);
      relCnt  <= '0;
    end else begin
      relCnt  <= relCnt + CNT_W'(slotRelease);
    end
  end

  for (genvar g = 0; g < NUM_CLUSTERS; g++) begin : gCl
    logic [CNT_W-1:0]        evCnt, evSnap, excMag;
    logic signed [CNT_W:0]   excess;
    logic                    negNow, satNow, excNeg, excSat;
    logic [WW-1:0]           ewMag, clampW;
    logic signed [SW-1:0]    wNext;
    logic [REM_W-1:0]        divNum, divDen;
    logic [FRAC_BITS-1:0]    divQ;
    logic [PW-1:0]           prod;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        evCnt  <= '0;
        evSnap <= '0;
      end else if (ctrl.snap) begin
        evSnap <= evCnt + CNT_W'(convPulse[g]);
        evCnt  <= '0;
      end else begin
        evCnt  <= evCnt + CNT_W'(convPulse[g]);
      end
    end
    assign snapCnt[g] = evSnap;

    // Chained counts: own surplus is the difference to the predecessor
    if (g == 0) begin : gHead
      assign excess = $signed({1'b0, evSnap});
    end else begin : gLink
      assign excess = $signed({1'b0, evSnap}) - $signed({1'b0, snapCnt[g-1]});
    end

    assign negNow = excess[CNT_W];
    assign excMag = negNow ? CNT_W'(-excess) : CNT_W'(excess);
    assign satNow = (excMag >= relSnap);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        excNeg <= 1'b0;
        excSat <= 1'b0;
      end else if (ctrl.loadEs) begin
        excNeg <= negNow;
        excSat <= satNow;
      end
    end

    assign ewMag = excSat ? ONE : WW'(divQ);
    assign wNext = excNeg ? ($signed({2'b00, wCur[g]}) + $signed({2'b00, ewMag}))
                          : ($signed({2'b00, wCur[g]}) - $signed({2'b00, ewMag}));

    always_comb begin
      if (wNext < MIN_S)      clampW = MIN_W;
      else if (wNext > ONE_S) clampW = ONE;
      else                    clampW = WW'(wNext);
    end
    assign wClamp[g] = clampW;

    // One divider per cluster, used twice per reconfiguration
    assign divNum = ctrl.loadEs ? (satNow ? '0 : REM_W'(excMag))
                                : ((g == 0) ? '0 : REM_W'(clampW));
    assign divDen = ctrl.loadEs ? REM_W'(relSnap) : REM_W'(wSum);

    swr_frac_div #(
      .REM_W (REM_W),
      .FRAC  (FRAC_BITS),
      .BPC   (BITS_PER_STEP)
    ) u_div (
      .clk   (clk),
      .rstN  (rstN),
      .load  (ctrl.loadEs | ctrl.loadNorm),
      .numIn (divNum),
      .denIn (divDen),
      .quot  (divQ)
    );
    assign quot[g] = divQ;

    assign prod = PW'(wCur[g]) * PW'(WINDOW);
    assign slotQuota[g*QUOTA_W +: QUOTA_W] = prod[FRAC_BITS +: QUOTA_W];
    assign weightsOut[g*WW +: WW]          = wCur[g];
  end

  always_comb begin
    wSum = '0;
    qSum = '0;
    for (int i = 0; i < NUM_CLUSTERS; i++) begin
      wSum = wSum + SUM_W'(wClamp[i]);
      if (i > 0) qSum = qSum + SUM_W'(quot[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weightValid <= 1'b0;
      for (int i = 0; i < NUM_CLUSTERS; i++) wCur[i] <= START_W;
    end else begin
      weightValid <= ctrl.commit;
      if (ctrl.commit && relSnap != '0) begin
        for (int i = 0; i < NUM_CLUSTERS; i++) begin
          if (i == 0) wCur[i] <= WW'(SUM_W'(ONE) - qSum);
          else        wCur[i] <= WW'(quot[i]);
        end
      end
    end
  end
endmodule

// File: rtl/slot_weight_rebalancer.sv
module slot_weight_rebalancer import swr_pkg::*; #(
  parameter int NUM_CLUSTERS  = 4,
  parameter int WINDOW        = 300,
  parameter int RECONF_LAT    = 20,
  parameter int FRAC_BITS     = 15,
  parameter int MIN_SHIFT     = 6,
  parameter int BITS_PER_STEP = 2
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  logic [NUM_CLUSTERS-1:0]                  convPulse,
  input  logic                                     slotRelease,
  output logic [NUM_CLUSTERS*(FRAC_BITS+1)-1:0]    weightsOut,
  output logic                                     weightValid,
  output logic [NUM_CLUSTERS*$clog2(WINDOW+1)-1:0] slotQuota
);
  localparam int STEPS = (FRAC_BITS + BITS_PER_STEP - 1) / BITS_PER_STEP;

  swrCtrl_t ctrl;

  swr_ctrl #(
    .WINDOW     (WINDOW),
    .RECONF_LAT (RECONF_LAT),
    .STEPS      (STEPS)
  ) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .ctrl (ctrl)
  );

  swr_datapath #(
    .NUM_CLUSTERS  (NUM_CLUSTERS),
    .WINDOW        (WINDOW),
    .FRAC_BITS     (FRAC_BITS),
    .MIN_SHIFT     (MIN_SHIFT),
    .BITS_PER_STEP (BITS_PER_STEP)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .convPulse   (convPulse),
    .slotRelease (slotRelease),
    .weightsOut  (weightsOut),
    .weightValid (weightValid),
    .slotQuota   (slotQuota)
  );
endmodule

// File: rtl/swr_checker.sv
module swr_checker #(
  parameter int NUM_CLUSTERS = 4,
  parameter int WINDOW       = 300,
  parameter int RECONF_LAT   = 20,
  parameter int FRAC_BITS    = 15
) (
  input logic                                     clk,
  input logic                                     rstN,
  input logic [NUM_CLUSTERS-1:0]                  convPulse,
  input logic                                     slotRelease,
  input logic [NUM_CLUSTERS*(FRAC_BITS+1)-1:0]    weightsOut,
  input logic                                     weightValid,
  input logic [NUM_CLUSTERS*$clog2(WINDOW+1)-1:0] slotQuota
);
  localparam int WW  = FRAC_BITS + 1;
  localparam int QW  = $clog2(WINDOW + 1);
  localparam int ONE = 1 << FRAC_BITS;

  int  phase;
  bit  seenWin;
  int  wSum, qSum;
  bit  allStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= 0;
      seenWin <= 1'b0;
    end else begin
      phase <= (phase == WINDOW - 1) ? 0 : phase + 1;
      if (phase == WINDOW - 1) seenWin <= 1'b1;
    end
  end

  always_comb begin
    wSum = 0;
    qSum = 0;
    allStart = 1'b1;
    for (int i = 0; i < NUM_CLUSTERS; i++) begin
      wSum = wSum + int'(weightsOut[i*WW +: WW]);
      qSum = qSum + int'(slotQuota[i*QW +: QW]);
      if (int'(weightsOut[i*WW +: WW]) != ONE / NUM_CLUSTERS) allStart = 1'b0;
    end
  end

  // R1: reset weights held and no publication before the first window closes
  a_r1_reset_hold: assert property (@(posedge clk) disable iff (!rstN)
    !seenWin |-> (allStart && !weightValid));
  // R6: published weights always sum to one
  a_r6_sum_one: assert property (@(posedge clk) disable iff (!rstN)
    wSum == ONE);
  // R8: valid is a single-cycle pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    weightValid |=> !weightValid);
  // R8: weights change only with the valid pulse
  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    !weightValid |-> $stable(weightsOut));
  // R8: publication only at the fixed offset after a window end
  a_r8_on_time: assert property (@(posedge clk) disable iff (!rstN)
    weightValid |-> (phase == RECONF_LAT - 1 && seenWin));
  // R8: publication never skipped
  a_r8_not_missed: assert property (@(posedge clk) disable iff (!rstN)
    (phase == RECONF_LAT - 1 && seenWin) |-> weightValid);
  // R9: quotas never exceed the window
  a_r9_quota_bound: assert property (@(posedge clk) disable iff (!rstN)
    qSum <= WINDOW);
endmodule

bind slot_weight_rebalancer swr_checker #(
  .NUM_CLUSTERS (NUM_CLUSTERS),
  .WINDOW       (WINDOW),
  .RECONF_LAT   (RECONF_LAT),
  .FRAC_BITS    (FRAC_BITS)
) u_swr_checker (.*);

// File: tb/slot_weight_rebalancer_bench.sv
module slot_weight_rebalancer_bench;
  localparam int NCL    = 4;
  localparam int WINDOW = 300;
  localparam int LAT    = 20;
  localparam int WW     = 16;
  localparam int QW     = 9;
  localparam int ONE    = 32768;
  localparam int MINW   = 512;
  localparam int NWIN   = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NCL-1:0]    convPulse = '0;
  logic              slotRelease = 1'b0;
  logic [NCL*WW-1:0] weightsOut;
  logic              weightValid;
  logic [NCL*QW-1:0] slotQuota;

  always #4 clk = ~clk;

  slot_weight_rebalancer u_slot_weight_rebalancer (
    .clk         (clk),
    .rstN        (rstN),
    .convPulse   (convPulse),
    .slotRelease (slotRelease),
    .weightsOut  (weightsOut),
    .weightValid (weightValid),
    .slotQuota   (slotQuota)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int curW[NCL];
  int pendW[NCL];
  int winCnt[NCL];
  int kWin;
  int publishAt = -1;
  bit pendKZero, lastKZero;
  bit published = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Behavioural model of one reconfiguration
  task automatic computeNext();
    int wc[NCL];
    int s, rest;
    if (kWin == 0) begin
      for (int i = 0; i < NCL; i++) pendW[i] = curW[i];
      pendKZero = 1;
      return;
    end
    pendKZero = 0;
    s = 0;
    for (int i = 0; i < NCL; i++) begin
      int es, mag, ew, wn;
      es  = (i == 0) ? winCnt[0] : winCnt[i] - winCnt[i-1];
      mag = (es < 0) ? -es : es;
      ew  = (mag >= kWin) ? ONE : (mag * ONE) / kWin;
      if (es < 0) ew = -ew;
      wn  = curW[i] - ew;
      if (wn < MINW) wn = MINW;
      if (wn > ONE)  wn = ONE;
      wc[i] = wn;
      s = s + wn;
    end
    rest = 0;
    for (int i = 1; i < NCL; i++) begin
      pendW[i] = (wc[i] * ONE) / s;
      rest = rest + pendW[i];
    end
    pendW[0] = ONE - rest;
  endtask

  task automatic pickInputs(input int n, output logic [NCL-1:0] cv, output logic rl);
    int w, p;
    w = n / WINDOW;
    p = n % WINDOW;
    cv = '0;
    rl = 1'b0;
    case (w)
      0: begin
        rl = 1'b1;
        cv[0] = (p % 4 == 0); cv[1] = (p % 3 == 0);
        cv[2] = (p % 2 == 0); cv[3] = (p % 5 == 0);
      end
      1: begin // no slots released: K = 0
        cv[0] = (p % 2 == 0); cv[1] = (p % 3 == 0);
        cv[2] = (p % 4 == 0); cv[3] = (p % 5 == 0);
      end
      2: begin // saturated corrections in both directions
        rl = (p % 2 == 0);
        cv[0] = 1'b1; cv[1] = (p % 3 == 0); cv[3] = (p % 7 == 0);
      end
      3: rl = 1'b1; // all surpluses zero
      4: begin
        rl = (p % 3 != 0);
        cv[3] = (p % 2 == 0);
      end
      default: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rl = lfsr[0] | lfsr[5];
        for (int i = 0; i < NCL; i++) cv[i] = lfsr[2*i+1] & lfsr[2*i+8];
      end
    endcase
  endtask

  initial begin
    for (int i = 0; i < NCL; i++) begin
      curW[i] = ONE / NCL;
      winCnt[i] = 0;
    end
    kWin = 0;
    lastKZero = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int n = 0; n < NWIN * WINDOW + LAT + 10; n++) begin
      logic [NCL-1:0] cv;
      logic rl;
      bit expValid;
      string tag;
      if (n > 0) @(negedge clk);
      expValid = (n == publishAt);
      if (expValid) begin
        for (int i = 0; i < NCL; i++) curW[i] = pendW[i];
        published = 1;
        lastKZero = pendKZero;
      end
      tag = !published ? "R1" : (lastKZero ? "R7" : "R2 R3 R4 R5 R6");
      for (int i = 0; i < NCL; i++)
        check(int'(weightsOut[i*WW +: WW]) == curW[i], tag, $sformatf("weight %0d cycle %0d", i, n),
              int'(weightsOut[i*WW +: WW]), curW[i]);
      check(weightValid == expValid, (n < WINDOW) ? "R1" : "R8", $sformatf("valid cycle %0d", n),
            int'(weightValid), int'(expValid));
      for (int i = 0; i < NCL; i++)
        check(int'(slotQuota[i*QW +: QW]) == (curW[i] * WINDOW) / ONE, "R9",
              $sformatf("quota %0d cycle %0d", i, n),
              int'(slotQuota[i*QW +: QW]), (curW[i] * WINDOW) / ONE);
      pickInputs(n, cv, rl);
      convPulse   = cv;
      slotRelease = rl;
      for (int i = 0; i < NCL; i++) winCnt[i] = winCnt[i] + int'(cv[i]);
      kWin = kWin + int'(rl);
      if (n % WINDOW == WINDOW - 1) begin
        computeNext();
        publishAt = n + LAT;
        for (int i = 0; i < NCL; i++) winCnt[i] = 0;
        kWin = 0;
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog expired before the run completed");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule